// File: doc/BRIEF.md
# Selectable Periodic Test Waveform Source

This block makes a stream of 16-bit signed sample words that follow one of four periodic shapes: sine, sawtooth, triangle or square. It is a deterministic test source for a serial-link transmit data path and sits beside a pseudo-random pattern source on that path. The shape is picked by a 2-bit select input, the same kind of control that picks the pseudo-random patterns. On the receive side, the looped-back samples can be stored and plotted, so a broken lane shows up as a distorted picture.

A single phase accumulator advances by a fixed step (the `PHASE_STEP` parameter) on every enabled clock. Each shape is a pure function of the current phase. The sine comes from a 256-entry quarter-wave table that is built at elaboration. Changing the select input restarts the phase at zero, so every new shape begins at the start of its period. Each produced word appears on the output one clock after the enabled edge and is marked by a valid strobe.

Top module: `wave_gen_top`

## Requirements
- R1: While `rstN` is low, `validOut` is 0 and `sampleOut` is 0. The phase is 0 and the remembered select is 0 (sine).
- R2: On a clock edge with `enIn` low and an unchanged select, `validOut` is 0 after the edge. `sampleOut` and the phase both keep their values.
- R3: On a clock edge with `enIn` high and an unchanged select, the word computed from the current phase p appears on `sampleOut` with `validOut` high after that edge. The phase then becomes (p + PHASE_STEP) mod 65536, so consecutive words use the phases 0, S, 2S and so on.
- R4: Select code 1 (sawtooth) gives the sample p - 32768. This is the phase with its top bit inverted, read as two's complement.
- R5: Select code 2 (triangle) folds the phase to u = p for p < 32768 and u = 65536 - p otherwise. The sample is min(2u - 32768, 32767). It rises from -32768 to a single peak of 32767 at p = 32768 and then falls, and the peak word is never produced twice in a row.
- R6: Select code 3 (square) gives +32767 when the top phase bit is 0 and -32768 when it is 1.
- R7: Select code 0 (sine) takes the table index k from bits 13..6 of the phase. When bit 14 is set, the index is mirrored to 255 - k. The magnitude is round(32767 * sin(pi * (k + 0.5) / 512)), and it is negated when bit 15 is set.
- R8: On any clock edge where `selIn` differs from the select seen at the previous edge, the phase is cleared to 0 and `validOut` is 0 after the edge, whatever `enIn` is. `sampleOut` holds its value. The next enabled edge produces the new shape at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| enIn | input | 1 | Produce one sample on this edge |
| selIn | input | 2 | Shape: 0 sine, 1 sawtooth, 2 triangle, 3 square |
| sampleOut | output | 16 | Two's-complement sample word |
| validOut | output | 1 | High for one clock per produced sample |

## Verification
The hardest case to reach is a select change that lands in an enable gap or in the middle of a period. The change must restart the phase without emitting a word, and a rewrite of the same code must not disturb the phase. The stimulus walks through every shape, including a return to an earlier one. It switches shapes both with enable high and inside idle bursts, and it rewrites the current code. Each run lasts several periods with an odd step, so the sine mirror and sign boundaries and the triangle fold are all crossed at many different phase offsets.

// File: rtl/wave_gen_pkg.sv
package wave_gen_pkg;

  typedef enum logic [1:0] {
    SHAPE_SINE   = 2'd0,
    SHAPE_SAW    = 2'd1,
    SHAPE_TRI    = 2'd2,
    SHAPE_SQUARE = 2'd3
  } shape_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clearPhase;
    logic   advance;
    shape_e shape;
  } ctrl_s;

endpackage

// File: rtl/wave_gen_ctrl.sv
module wave_gen_ctrl
  import wave_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enIn,
  input  shape_e selIn,
  output ctrl_s  ctrlOut
);

  shape_e lastSel;
  logic   selChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastSel <= SHAPE_SINE;
    else       lastSel <= selIn;
  end

  always_comb begin
    selChange          = (selIn != lastSel);
    ctrlOut.clearPhase = selChange;
    ctrlOut.advance    = enIn && !selChange;
    ctrlOut.shape      = selIn;
  end

endmodule

// File: rtl/wave_gen_shaper.sv
module wave_gen_shaper
  import wave_gen_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LUT_ABITS = 8
) (
  input  logic [SAMPLE_W-1:0] phaseIn,
  input  shape_e              shapeIn,
  output logic [SAMPLE_W-1:0] sampleOut
);

  localparam int  W         = SAMPLE_W;
  localparam int  LUT_DEPTH = 1 << LUT_ABITS;
  localparam int  AMP       = (1 << (W - 1)) - 1;
  localparam real PI_R      = 3.141592653589793;

  function automatic int sineEntry(input int k);
    real ang;
    ang = PI_R * (real'(k) + 0.5) / real'(2 * LUT_DEPTH);
    return $rtoi(real'(AMP) * $sin(ang) + 0.5);
  endfunction

  logic [W-2:0] sineRom [LUT_DEPTH];

  for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_rom
    localparam int ENTRY = sineEntry(k);
    assign sineRom[k] = ENTRY[W-2:0];
  end

  logic [LUT_ABITS-1:0] lutIdx;
  logic [W-2:0]         sineMag;
  logic [W-1:0]         sineVal;
  logic [W-1:0]         sawVal;
  logic [W-1:0]         sqVal;
  logic [W-1:0]         triFold;
  logic [W:0]           triDbl;
  logic [W-1:0]         triOff;
  logic [W-1:0]         triVal;

  always_comb begin
    // sine: quarter table, mirrored by bit W-2, sign from bit W-1
    lutIdx  = phaseIn[W-3 -: LUT_ABITS];
    if (phaseIn[W-2]) lutIdx = ~lutIdx;
    sineMag = sineRom[lutIdx];
    sineVal = phaseIn[W-1] ? (W'(0) - {1'b0, sineMag}) : {1'b0, sineMag};

    // sawtooth: offset binary to two's complement
    sawVal  = {~phaseIn[W-1], phaseIn[W-2:0]};

    // square
    sqVal   = phaseIn[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

    // triangle: fold, double, saturate the single top value
    triFold = phaseIn[W-1] ? (W'(0) - phaseIn) : phaseIn;
    triDbl  = {triFold, 1'b0};
    triOff  = triDbl[W] ? {W{1'b1}} : triDbl[W-1:0];
    triVal  = {~triOff[W-1], triOff[W-2:0]};

    unique case (shapeIn)
      SHAPE_SINE:   sampleOut = sineVal;
      SHAPE_SAW:    sampleOut = sawVal;
      SHAPE_TRI:    sampleOut = triVal;
      SHAPE_SQUARE: sampleOut = sqVal;
      default:      sampleOut = '0;
    endcase
  end

endmodule

// File: rtl/wave_gen_datapath.sv
module wave_gen_datapath
  import wave_gen_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int LUT_ABITS  = 8,
  parameter int PHASE_STEP = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               ctrlIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                validOut
);

  localparam int W = SAMPLE_W;
  localparam logic [W-1:0] STEP_V = PHASE_STEP[W-1:0];

  logic [W-1:0] phaseQ;
  logic [W-1:0] shaped;

  wave_gen_shaper #(
    .SAMPLE_W (SAMPLE_W),
    .LUT_ABITS(LUT_ABITS)
  ) shaper_i (
    .phaseIn  (phaseQ),
    .shapeIn  (ctrlIn.shape),
    .sampleOut(shaped)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= '0;
      sampleOut <= '0;
      validOut  <= 1'b0;
    end else if (ctrlIn.clearPhase) begin
      phaseQ    <= '0;
      validOut  <= 1'b0;
    end else if (ctrlIn.advance) begin
      phaseQ    <= phaseQ + STEP_V;
      sampleOut <= shaped;
      validOut  <= 1'b1;
    end else begin
      validOut  <= 1'b0;
    end
  end

endmodule

// File: rtl/wave_gen_top.sv
module wave_gen_top
  import wave_gen_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int LUT_ABITS  = 8,
  parameter int PHASE_STEP = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enIn,
  input  logic [1:0]          selIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                validOut
);

  ctrl_s ctrlBus;

  wave_gen_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .enIn   (enIn),
    .selIn  (shape_e'(selIn)),
    .ctrlOut(ctrlBus)
  );

  wave_gen_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .LUT_ABITS (LUT_ABITS),
    .PHASE_STEP(PHASE_STEP)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .sampleOut(sampleOut),
    .validOut (validOut)
  );

endmodule

// File: rtl/wave_gen_checker.sv
module wave_gen_checker #(
  parameter int SAMPLE_W   = 16,
  parameter int PHASE_STEP = 1024
) (
  input logic                clk,
  input logic                rstN,
  input logic                enIn,
  input logic [1:0]          selIn,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                validOut,
  input logic                clearPhase,
  input logic [SAMPLE_W-1:0] phaseVal
);

  localparam int W = SAMPLE_W;
  localparam logic [W-1:0] STEP_V = PHASE_STEP[W-1:0];
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  // R1: reset leaves no valid word
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !validOut);

  // R2: idle edge produces nothing and keeps the word
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> !validOut);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> $stable(sampleOut));

  // R4: consecutive sawtooth words differ by the phase step
  a_r4_saw_step: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(validOut) && $past(selIn) == 2'd1 && $past(selIn, 2) == 2'd1)
      |-> (W'(sampleOut - $past(sampleOut)) == STEP_V));

  // R5: triangle peak never repeats
  a_r5_single_peak: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(validOut) && $past(selIn) == 2'd2 && $past(selIn, 2) == 2'd2)
      |-> !(sampleOut == POS_MAX && $past(sampleOut) == POS_MAX));

  // R6: square takes only the two extreme codes
  a_r6_square_levels: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(selIn) == 2'd3) |-> (sampleOut == POS_MAX || sampleOut == NEG_MAX));

  // R8: select change restarts the phase and emits nothing
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    clearPhase |=> (!validOut && phaseVal == '0));

endmodule

bind wave_gen_top wave_gen_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .PHASE_STEP(PHASE_STEP)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .enIn      (enIn),
  .selIn     (selIn),
  .sampleOut (sampleOut),
  .validOut  (validOut),
  .clearPhase(ctrlBus.clearPhase),
  .phaseVal  (dp_i.phaseQ)
);

// File: tb/wave_gen_tb.sv
module wave_gen_top_tb_top;

  localparam int  STEP = 341;
  localparam real PI_R = 3.141592653589793;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enIn = 1'b0;
  logic [1:0]  selIn = 2'd0;
  logic [15:0] sampleOut;
  logic        validOut;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // behavioural reference state
  int    mPhase = 0;
  int    mLastSel = 0;
  int    mSample = 0;
  bit    mValid = 0;
  string mTag = "R1";

  always #2.5 clk = ~clk;

  wave_gen_top #(.PHASE_STEP(STEP)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .enIn     (enIn),
    .selIn    (selIn),
    .sampleOut(sampleOut),
    .validOut (validOut)
  );

  function automatic int refShape(int s, int p);
    int q, m, u, v;
    case (s)
      0: begin
        q = (p >> 6) & 255;
        if ((p & 16384) != 0) q = 255 - q;
        m = $rtoi(32767.0 * $sin(PI_R * (real'(q) + 0.5) / real'(512)) + 0.5);
        return ((p & 32768) != 0) ? -m : m;
      end
      1: return p - 32768;
      2: begin
        u = (p < 32768) ? p : 65536 - p;
        v = 2 * u - 32768;
        return (v > 32767) ? 32767 : v;
      end
      default: return (p < 32768) ? 32767 : -32768;
    endcase
  endfunction

  function automatic string shapeTag(int s);
    case (s)
      0: return "R7 (R3)";
      1: return "R4 (R3)";
      2: return "R5 (R3)";
      default: return "R6 (R3)";
    endcase
  endfunction

  // advance the model by one rising edge using the inputs now driven
  task automatic modelEdge();
    if (!rstN) begin
      mPhase = 0; mLastSel = 0; mSample = 0; mValid = 0; mTag = "R1";
    end else if (int'(selIn) != mLastSel) begin
      mPhase = 0; mValid = 0; mLastSel = int'(selIn); mTag = "R8";
    end else if (enIn) begin
      mSample = refShape(int'(selIn), mPhase);
      mPhase  = (mPhase + STEP) % 65536;
      mValid  = 1;
      mTag    = shapeTag(int'(selIn));
    end else begin
      mValid = 0; mTag = "R2";
    end
  endtask

  task automatic compare();
    int got;
    got = int'($signed(sampleOut));
    vectors++;
    if (validOut !== mValid || got != mSample) begin
      misses++;
      $display("FAIL %s: valid=%0b sample=%0d expected valid=%0b sample=%0d",
               mTag, validOut, got, mValid, mSample);
    end
  endtask

  // one clock: check last edge, drive new inputs, predict next edge
  task automatic step(bit rst, bit en, int sel);
    @(negedge clk);
    compare();
    rstN  = !rst;
    enIn  = en;
    selIn = sel[1:0];
    modelEdge();
  endtask

  task automatic runShape(int sel, int cycles);
    for (int i = 0; i < cycles; i++) begin
      bit en;
      en = !((i % 53) >= 50) && !((i % 17) == 9);
      step(0, en, sel);
    end
  endtask

  initial begin
    // R1: reset state
    modelEdge();
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    // R3 and R7: sine, starting from the reset phase
    runShape(0, 700);
    // R8: switch to sawtooth with enable high, R4
    runShape(1, 700);
    // R8: switch inside an idle burst, then R5 triangle
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 2);
    runShape(2, 700);
    // R6: square
    runShape(3, 700);
    // rewriting the same code must not restart (R8 negative case)
    for (int i = 0; i < 5; i++) step(0, 1, 3);
    // back to sine mid-period (R8, R7)
    runShape(0, 500);
    // R2: long idle stretch holding the word
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    runShape(0, 100);
    // R1: reset in mid-run, then triangle again
    for (int i = 0; i < 3; i++) step(1, 1, 2);
    runShape(2, 400);
    // final check of the last edge
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule